// File: doc/BRIEF.md
# Channel Enable and Overload Latch

This block produces the gate-enable signals for eight low-side switch channels. Each channel is commanded by one bit of a control word. The first two channels also have an active-low parallel input, so they can be driven by PWM without going through the serial link. A common internal reset turns every channel off. The reset is raised by the synchronous fabric reset, by a low external reset pin, or by an undervoltage flag.

Each channel has an overload latch. When a fault hits a channel that is commanded on, the latch sets and the channel's gate drops on the same clock edge. Channels 1 to 6 trip on overcurrent. Channels 7 and 8 current-regulate, so they trip only on overtemperature. A latched channel stays off until its command goes off, which clears the latch. A later on-command then retries the channel. All outputs are registered, so every result follows its inputs by one clock.

Top module: `chen_top`

## Requirements
- R1: Channel 1 is commanded on when `ctrl_bits[0]` is 1 or `par_on_n[0]` is 0. Channel 2 is commanded on when `ctrl_bits[1]` is 1 or `par_on_n[1]` is 0. A parallel input held high, which is its unconnected default, leaves the channel under control of its bit alone.
- R2: Channels 3 to 8 are commanded on only by `ctrl_bits[2]` to `ctrl_bits[7]`, where 1 means on.
- R3: While `rst` is 1, `ext_rst_n` is 0 or `uv_flag` is 1, the next edge forces every bit of `gate_en` and of `ovl_state` to 0.
- R4: On channels 1 to 6, an `oc_flag` bit seen while the channel is commanded on sets that channel's `ovl_state` bit, and the same edge drives its `gate_en` bit to 0.
- R5: On channels 1 to 6, `ot_flag` has no effect.
- R6: On channels 7 and 8, `oc_flag` has no effect, and an `ot_flag` bit seen while the channel is commanded on sets the latch and turns the gate off, as in R4.
- R7: A set overload latch keeps its channel off while the command stays on, even after the fault flag returns to 0.
- R8: A channel commanded off has its latch cleared on the next edge, so that a later on-command turns the gate on again.
- R9: A fault flag on a channel that is commanded off does not set that channel's latch.
- R10: Each `gate_en` bit equals commanded-on AND NOT latch AND NOT internal reset, registered. A change at the inputs shows at the outputs one edge later and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_bits | input | 8 | Control word; bit i commands channel i+1 |
| par_on_n | input | 2 | Active-low parallel commands for channels 1 and 2 |
| oc_flag | input | 8 | Per-channel overcurrent flags |
| ot_flag | input | 8 | Per-channel overtemperature flags |
| ext_rst_n | input | 1 | External active-low reset |
| uv_flag | input | 1 | Undervoltage flag |
| gate_en | output | 8 | Registered gate enables |
| ovl_state | output | 8 | Registered overload latch states |

## Verification
Both outputs are registered, so every result falls due exactly one rising edge after the inputs that cause it. This holds for the command word, the parallel inputs, the faults, the latch clear and all three reset sources. The bench drives inputs on the falling edge and compares both output vectors on the next falling edge, which is half a period after the rising edge that updates them. Before that edge it also samples once and expects the previous values, which confirms that there is no combinational path from the inputs to the outputs.

// File: rtl/chen_pkg.sv
package chen_pkg;
  localparam int NUM_CH  = 8;
  localparam int NUM_PAR = 2;
  localparam int NUM_OC  = 6;

  typedef enum logic {
    TRIP_OVERCURRENT = 1'b0,
    TRIP_OVERTEMP    = 1'b1
  } trip_src_e;

  function automatic trip_src_e chan_trip_src(input int idx, input int num_oc);
    return (idx < num_oc) ? TRIP_OVERCURRENT : TRIP_OVERTEMP;
  endfunction
endpackage

// File: rtl/chen_cmd_merge.sv
module chen_cmd_merge #(
  parameter int NUM_CH  = 8,
  parameter int NUM_PAR = 2
) (
  input  logic [NUM_CH-1:0]  ctrl_bits,
  input  logic [NUM_PAR-1:0] par_on_n,
  output logic [NUM_CH-1:0]  cmd_on
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i < NUM_PAR) begin : g_par
      // parallel input low, or the control bit, turns the channel on
      assign cmd_on[i] = ctrl_bits[i] | ~par_on_n[i];
    end else begin : g_ser
      assign cmd_on[i] = ctrl_bits[i];
    end
  end
endmodule

// File: rtl/chen_rst_combine.sv
module chen_rst_combine (
  input  logic rst,
  input  logic ext_rst_n,
  input  logic uv_flag,
  output logic int_rst
);
  assign int_rst = rst | ~ext_rst_n | uv_flag;
endmodule

// File: rtl/chen_chan_slice.sv
module chen_chan_slice
  import chen_pkg::*;
#(
  parameter trip_src_e TRIP_SRC = TRIP_OVERCURRENT
) (
  input  logic clk,
  input  logic int_rst,
  input  logic cmd_on,
  input  logic oc_flag,
  input  logic ot_flag,
  output logic gate_en,
  output logic ovl_q
);
  logic trip;
  logic ovl_d;

  assign trip = (TRIP_SRC == TRIP_OVERCURRENT) ? oc_flag : ot_flag;

  always_comb begin
    if (!cmd_on) ovl_d = 1'b0;
    else         ovl_d = ovl_q | trip;
  end

  always_ff @(posedge clk) begin
    if (int_rst) begin
      ovl_q   <= 1'b0;
      gate_en <= 1'b0;
    end else begin
      ovl_q   <= ovl_d;
      gate_en <= cmd_on & ~ovl_d;
    end
  end

  // R4 / R6: fault on a commanded channel latches and turns it off at once
  a_r4_trip_latches_off: assert property (@(posedge clk) disable iff (int_rst)
    (cmd_on && trip) |=> (ovl_q && !gate_en));

  // R8: command off clears latch
  a_r8_cmd_off_clears: assert property (@(posedge clk) disable iff (int_rst)
    !cmd_on |=> (!ovl_q && !gate_en));

  // R5 / R6: the flag of the other group does not stop a healthy channel
  a_r5_r6_other_flag_ignored: assert property (@(posedge clk) disable iff (int_rst)
    (cmd_on && !ovl_q && !trip) |=> gate_en);

  // R7: latched channel stays off while still commanded
  a_r7_latch_holds: assert property (@(posedge clk) disable iff (int_rst)
    (cmd_on && ovl_q) |=> (ovl_q && !gate_en));

  a_r10_never_both: assert property (@(posedge clk) disable iff (int_rst)
    !(ovl_q && gate_en));
endmodule

// File: rtl/chen_top.sv
module chen_top
  import chen_pkg::*;
#(
  parameter int CH  = NUM_CH,
  parameter int PAR = NUM_PAR,
  parameter int OC  = NUM_OC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] ctrl_bits,
  input  logic [PAR-1:0] par_on_n,
  input  logic [CH-1:0] oc_flag,
  input  logic [CH-1:0] ot_flag,
  input  logic          ext_rst_n,
  input  logic          uv_flag,
  output logic [CH-1:0] gate_en,
  output logic [CH-1:0] ovl_state
);
  logic [CH-1:0] cmd_on;
  logic          int_rst;

  chen_cmd_merge #(.NUM_CH(CH), .NUM_PAR(PAR)) u_merge (
    .ctrl_bits(ctrl_bits),
    .par_on_n (par_on_n),
    .cmd_on   (cmd_on)
  );

  chen_rst_combine u_rst (
    .rst      (rst),
    .ext_rst_n(ext_rst_n),
    .uv_flag  (uv_flag),
    .int_rst  (int_rst)
  );

  for (genvar i = 0; i < CH; i++) begin : g_slice
    chen_chan_slice #(.TRIP_SRC(chan_trip_src(i, OC))) u_slice (
      .clk    (clk),
      .int_rst(int_rst),
      .cmd_on (cmd_on[i]),
      .oc_flag(oc_flag[i]),
      .ot_flag(ot_flag[i]),
      .gate_en(gate_en[i]),
      .ovl_q  (ovl_state[i])
    );
  end

  // R3: external reset or undervoltage clears everything on the next edge
  a_r3_reset_forces_off: assert property (@(posedge clk) disable iff (rst)
    (!ext_rst_n || uv_flag) |=> (gate_en == '0 && ovl_state == '0));

  // R1: a low parallel input with no fault turns the channel on
  for (genvar p = 0; p < PAR; p++) begin : g_par_chk
    a_r1_par_low_on: assert property (@(posedge clk) disable iff (int_rst)
      (!par_on_n[p] && !ovl_state[p] && !oc_flag[p]) |=> gate_en[p]);
  end
endmodule

// File: tb/chen_top_tb_top.sv
module chen_top_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] ctrl_bits;
  logic [1:0] par_on_n;
  logic [7:0] oc_flag, ot_flag;
  logic       ext_rst_n, uv_flag;
  logic [7:0] gate_en, ovl_state;

  int errors = 0;
  int checks = 0;
  logic [7:0] m_gate, m_ovl;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  chen_top dut_i (
    .clk(clk), .rst(rst), .ctrl_bits(ctrl_bits), .par_on_n(par_on_n),
    .oc_flag(oc_flag), .ot_flag(ot_flag), .ext_rst_n(ext_rst_n),
    .uv_flag(uv_flag), .gate_en(gate_en), .ovl_state(ovl_state)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (gate_en !== m_gate || ovl_state !== m_ovl) begin
      errors++;
      $display("FAIL %s: gate_en=%b ovl=%b expected gate_en=%b ovl=%b",
               tag, gate_en, ovl_state, m_gate, m_ovl);
    end
  endtask

  // apply inputs at the falling edge, update the model, check one edge later
  task automatic step(input logic [7:0] c, input logic [1:0] p, input logic [7:0] oc,
                      input logic [7:0] ot, input logic nr, input logic uv,
                      input string tag, input bit early);
    logic [7:0] cmd, trip, nov;
    logic ir;
    ctrl_bits = c; par_on_n = p; oc_flag = oc; ot_flag = ot;
    ext_rst_n = nr; uv_flag = uv;
    if (early) begin #5; check("R10 early"); end
    ir  = rst | ~nr | uv;
    cmd = c | {6'b0, ~p};
    trip = {ot[7:6], oc[5:0]};
    nov = ir ? 8'h00 : (cmd & (m_ovl | trip));
    m_ovl  = nov;
    m_gate = ir ? 8'h00 : (cmd & ~nov);
    @(posedge clk); @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; ctrl_bits = 8'hFF; par_on_n = 2'b00; oc_flag = 0; ot_flag = 0;
    ext_rst_n = 1'b1; uv_flag = 1'b0;
    m_gate = 0; m_ovl = 0;
    repeat (3) @(negedge clk);
    check("R3 reset state");
    rst = 1'b0;

    // R1 R2 R10: full sweep of control word and parallel inputs
    for (int c = 0; c < 256; c++)
      for (int p = 0; p < 4; p++)
        step(c[7:0], p[1:0], 8'h00, 8'h00, 1'b1, 1'b0, "R1 R2 sweep", 1'b1);

    // R4: overcurrent on channel 3, R7: hold, R8: clear and retry
    step(8'h04, 2'b11, 8'h00, 8'h00, 1'b1, 1'b0, "R2 ch3 on", 1'b0);
    step(8'h04, 2'b11, 8'h04, 8'h00, 1'b1, 1'b0, "R4 ch3 trip", 1'b0);
    step(8'h04, 2'b11, 8'h00, 8'h00, 1'b1, 1'b0, "R7 ch3 hold", 1'b0);
    step(8'h00, 2'b11, 8'h00, 8'h00, 1'b1, 1'b0, "R8 ch3 clear", 1'b0);
    step(8'h04, 2'b11, 8'h00, 8'h00, 1'b1, 1'b0, "R8 ch3 retry", 1'b0);
    // R1 via parallel input with overcurrent on channel 1
    step(8'h00, 2'b10, 8'h01, 8'h00, 1'b1, 1'b0, "R4 ch1 par trip", 1'b0);
    step(8'h00, 2'b11, 8'h00, 8'h00, 1'b1, 1'b0, "R8 ch1 par release", 1'b0);
    // R5: overtemperature ignored on channels 1..6
    step(8'h3F, 2'b11, 8'h00, 8'h3F, 1'b1, 1'b0, "R5 ot ignored low group", 1'b0);
    // R6: overcurrent ignored, overtemperature latches on channels 7, 8
    step(8'hC0, 2'b11, 8'hC0, 8'h00, 1'b1, 1'b0, "R6 oc ignored ch7 ch8", 1'b0);
    step(8'hC0, 2'b11, 8'h00, 8'h80, 1'b1, 1'b0, "R6 ot trips ch8", 1'b0);
    step(8'hC0, 2'b11, 8'h00, 8'h00, 1'b1, 1'b0, "R7 ch8 hold", 1'b0);
    // R9: faults while commanded off
    step(8'h00, 2'b11, 8'hFF, 8'hFF, 1'b1, 1'b0, "R9 fault while off", 1'b0);
    step(8'hFF, 2'b11, 8'h00, 8'h00, 1'b1, 1'b0, "R9 all on after", 1'b0);
    // R3: external reset and undervoltage
    step(8'hFF, 2'b00, 8'h00, 8'h00, 1'b0, 1'b0, "R3 ext reset", 1'b0);
    step(8'hFF, 2'b00, 8'h00, 8'h00, 1'b1, 1'b0, "R3 ext release", 1'b0);
    step(8'hFF, 2'b00, 8'h01, 8'h00, 1'b1, 1'b0, "R4 ch1 trip pre-uv", 1'b0);
    step(8'hFF, 2'b00, 8'h00, 8'h00, 1'b1, 1'b1, "R3 undervoltage", 1'b0);
    step(8'hFF, 2'b00, 8'h00, 8'h00, 1'b1, 1'b0, "R3 uv release", 1'b0);

    // mixed pseudo-random traffic, all requirements
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] a, b;
      rng = nxt(rng); a = rng;
      rng = nxt(rng); b = rng;
      step(a[7:0], a[9:8], a[23:16] & b[7:0] & b[15:8],
           a[31:24] & b[23:16] & b[31:24], ~(a[10] & a[11] & a[12] & a[13]),
           b[0] & b[1] & b[2] & b[3] & b[4], "R4 R6 R7 R8 R9 random", k[0]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule